// File: doc/BRIEF.md
# Wavetable DMA Transfer Engine

This block copies a block of bytes between a system-side byte stream and a 20-bit sample memory on the card, in either direction. Software sets the card position through two registers. The position register counts in 16-byte paragraphs. The offset register adds a byte offset, of which only the low four bits take part in addressing. A write to the control register with the request bit set launches a transfer, and the unit count is taken from the system side at that moment. When a 16-bit channel is attached, the card address is folded so that each unit of two bytes lands at a doubled address. Toward the card, the block can flip the sign bit of sample bytes.

On the final byte, the request bit drops, the position and offset registers move past the block, and a terminal-count status can raise the interrupt line. Software acknowledges the interrupt by reading the control register. That read reports the pending status and clears it. The system DMA controller and the card memory are modelled as plain valid/ready style handshakes, and one byte moves in each cycle in which both sides agree.

Top module: `wt_dma_engine`

## Requirements
- R1: After reset, the control, position and offset registers read zero (a narrow channel attached), `irq` is low and `mem_req` is low.
- R2: With a narrow channel, the first card byte address is position*16 + offset[3:0]. It rises by one after each moved byte and wraps from 0xFFFFF to 0.
- R3: With `wide_chan` high, each unit is two bytes. The first address is the plain address A from R2 folded as (A & 0xC0000) + 2*(A & 0x1FFF0), and it then rises by one per byte.
- R4: Control bit 1 selects the direction. At 0, bytes go from `sys_in_*` to memory with `mem_we`=1. At 1, memory bytes go out on `sys_out_*` unchanged, with `mem_we`=0.
- R5: Toward the card, with control bit 7 set, bit 7 of a byte is inverted with one exception. When control bit 6 is set, the first byte of each unit is left unchanged. The second byte of a wide unit is always inverted. Nothing is inverted when control bit 7 is clear, or in the direction toward the system.
- R6: A byte moves only in a cycle with `mem_req` and `mem_ack` both high. In any other cycle the address holds and `sys_out_valid` stays low.
- R7: Writing the control register (select 0) with bit 0 set while idle starts a transfer of `sys_count`+1 units. Bit 0 reads 1 until the final byte and 0 afterwards. Bit 0 never reads 1 while the block is idle.
- R8: At terminal count, the position register (select 1) grows by units>>4 and the offset register (select 2) becomes (units + old offset) & 0xF.
- R9: At terminal count with control bit 5 set, a status bit becomes pending and `irq` rises in the next cycle.
- R10: A control read returns the stored value with bit 6 ORed with the pending status and bit 2 ORed with `wide_chan`. The read clears the pending status, which drops `irq`, and clears stored bits 6 and 2.
- R11: Writing the position register keeps only the low four bits of the offset register.
- R12: When a control read falls in the cycle of the final byte, the read returns the status as it was before terminal count, and the new pending status survives the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control) |
| reg_sel | input | 2 | 0 control, 1 position, 2 offset, 3 reads all ones |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_sel` |
| irq | output | 1 | Terminal-count interrupt |
| wide_chan | input | 1 | A 16-bit system channel is attached |
| sys_count | input | CNT_W | Units minus one, sampled at start |
| sys_in_valid | input | 1 | System byte offered (toward card) |
| sys_in_data | input | 8 | System byte |
| sys_in_ready | output | 1 | System byte taken |
| sys_out_valid | output | 1 | Card byte offered to system |
| sys_out_data | output | 8 | Card byte to system |
| sys_out_ready | input | 1 | System can accept a byte |
| mem_req | output | 1 | Card memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Card byte address |
| mem_wdata | output | 8 | Byte written to card |
| mem_rdata | input | 8 | Byte read from card, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the access this cycle |

## Verification
The terminal count of a transfer and a control-register read can land in the same clock cycle. In that cycle, one path sets the pending status and clears the request bit, while the other reports the status and clears it along with stored bits 6 and 2. The bench provokes this by raising the control read together with a forced memory acknowledge on the last byte of a transfer with bit 5 set. It then judges three things: the value returned in that cycle must carry the old status and request bit 0 still set, `irq` must be high afterwards, and a second read must show the new status once and clear it.

// File: rtl/wtd_pkg.sv
package wtd_pkg;

    localparam int CARD_AW = 20;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_START = 2'd1;
    localparam logic [1:0] SEL_FINE  = 2'd2;

    // Control register bit positions (software visible)
    localparam int CB_REQ   = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_WIDE  = 2;
    localparam int CB_IRQEN = 5;
    localparam int CB_HALF  = 6;
    localparam int CB_SIGN  = 7;

    typedef struct packed {
        logic to_sys;
        logic sign_inv;
        logic half16;
        logic tc_irq_en;
        logic wide;
    } job_t;

    function automatic logic [CARD_AW-1:0] card_base(
        input logic [15:0] para,
        input logic [3:0]  nib,
        input logic        wide
    );
        logic [CARD_AW-1:0] a;
        a = {para, 4'h0} | {16'h0, nib};
        if (wide)
            a = (a & 20'hC0000) + ((a & 20'h1FFF0) << 1);
        return a;
    endfunction

    function automatic logic flip_msb(
        input logic to_sys,
        input logic sign_inv,
        input logic half16,
        input logic wide,
        input logic hi_byte
    );
        return sign_inv && !to_sys && ((wide && hi_byte) || !half16);
    endfunction

endpackage

// File: rtl/wtd_regs.sv
module wtd_regs
    import wtd_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int UW = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_sel,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic               wide_chan,
    input  logic [UW-1:0]      units_now,
    input  logic               busy,
    input  logic               done,
    output logic               start_fire,
    output job_t               job,
    output logic [CARD_AW-1:0] base_addr,
    output logic               irq
);
    logic [7:0]    ctrl_q;
    logic [15:0]   para_q;
    logic [7:0]    fine_q;
    logic          tc_q;
    job_t          job_q;
    logic [UW-1:0] units_q;
    logic [15:0]   para_step;
    logic [3:0]    fine_next;
    logic          ctrl_rd;

    assign ctrl_rd    = reg_rd && (reg_sel == SEL_CTRL);
    assign start_fire = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CB_REQ] && !busy;
    assign base_addr  = card_base(para_q, fine_q[3:0], wide_chan);
    assign para_step  = 16'(units_q >> 4);
    assign fine_next  = units_q[3:0] + fine_q[3:0];
    assign job        = job_q;
    assign irq        = tc_q;

    always_comb begin
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata = {8'h00, ctrl_q};
                reg_rdata[CB_HALF] = ctrl_q[CB_HALF] | tc_q;
                reg_rdata[CB_WIDE] = ctrl_q[CB_WIDE] | wide_chan;
            end
            SEL_START: reg_rdata = para_q;
            SEL_FINE:  reg_rdata = {8'h00, fine_q};
            default:   reg_rdata = 16'hFFFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            para_q  <= '0;
            fine_q  <= '0;
            tc_q    <= 1'b0;
            job_q   <= '0;
            units_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_CTRL:  ctrl_q <= reg_wdata[7:0];
                    SEL_START: begin
                        para_q <= reg_wdata;
                        fine_q <= {4'h0, fine_q[3:0]};
                    end
                    SEL_FINE:  fine_q <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (ctrl_rd) begin
                ctrl_q[CB_HALF] <= 1'b0;
                ctrl_q[CB_WIDE] <= 1'b0;
                tc_q            <= 1'b0;
            end
            if (start_fire) begin
                job_q.to_sys    <= reg_wdata[CB_DIR];
                job_q.sign_inv  <= reg_wdata[CB_SIGN];
                job_q.half16    <= reg_wdata[CB_HALF];
                job_q.tc_irq_en <= reg_wdata[CB_IRQEN];
                job_q.wide      <= wide_chan;
                units_q         <= units_now;
            end
            // Terminal count is applied last so it wins over a same-cycle read
            if (done) begin
                ctrl_q[CB_REQ] <= 1'b0;
                para_q         <= para_q + para_step;
                fine_q         <= {4'h0, fine_next};
                if (job_q.tc_irq_en)
                    tc_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wtd_mover.sv
module wtd_mover
    import wtd_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LW = CNT_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_fire,
    input  logic [CARD_AW-1:0] base_addr,
    input  logic [LW-1:0]      load_bytes,
    input  logic               to_sys,
    input  logic               sign_inv,
    input  logic               half16,
    input  logic               wide,
    input  logic               sys_in_valid,
    input  logic [7:0]         sys_in_data,
    output logic               sys_in_ready,
    output logic               sys_out_valid,
    output logic [7:0]         sys_out_data,
    input  logic               sys_out_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [CARD_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ack,
    output logic               busy,
    output logic               done
);
    logic               busy_q;
    logic [CARD_AW-1:0] addr_q;
    logic [LW-1:0]      left_q;
    logic               hi_q;
    logic               move;
    logic               flip;

    assign busy          = busy_q;
    assign mem_req       = busy_q && (to_sys ? sys_out_ready : sys_in_valid);
    assign mem_we        = busy_q && !to_sys;
    assign sys_in_ready  = busy_q && !to_sys && mem_ack;
    assign sys_out_valid = busy_q && to_sys && mem_ack;
    assign move          = mem_req && mem_ack;
    assign done          = move && (left_q == LW'(1));
    assign mem_addr      = addr_q;
    assign flip          = flip_msb(to_sys, sign_inv, half16, wide, hi_q);
    assign mem_wdata     = sys_in_data ^ {flip, 7'h00};
    assign sys_out_data  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            left_q <= '0;
            hi_q   <= 1'b0;
        end else if (start_fire) begin
            busy_q <= 1'b1;
            addr_q <= base_addr;
            left_q <= load_bytes;
            hi_q   <= 1'b0;
        end else if (move) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            hi_q   <= wide ? !hi_q : 1'b0;
            if (done)
                busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wt_dma_engine.sv
module wt_dma_engine
    import wtd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_sel,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               irq,
    input  logic               wide_chan,
    input  logic [CNT_W-1:0]   sys_count,
    input  logic               sys_in_valid,
    input  logic [7:0]         sys_in_data,
    output logic               sys_in_ready,
    output logic               sys_out_valid,
    output logic [7:0]         sys_out_data,
    input  logic               sys_out_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [CARD_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ack
);
    localparam int UW = CNT_W + 1;
    localparam int LW = CNT_W + 2;

    logic               busy_w;
    logic               done_w;
    logic               start_w;
    job_t               job_w;
    logic [CARD_AW-1:0] base_w;
    logic [UW-1:0]      units_now;
    logic [LW-1:0]      load_bytes;

    assign units_now  = UW'(sys_count) + UW'(1);
    assign load_bytes = wide_chan ? {units_now, 1'b0} : {1'b0, units_now};

    wtd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wide_chan(wide_chan), .units_now(units_now),
        .busy(busy_w), .done(done_w),
        .start_fire(start_w), .job(job_w), .base_addr(base_w),
        .irq(irq)
    );

    wtd_mover #(.CNT_W(CNT_W)) u_mover (
        .clk(clk), .rst(rst),
        .start_fire(start_w), .base_addr(base_w), .load_bytes(load_bytes),
        .to_sys(job_w.to_sys), .sign_inv(job_w.sign_inv),
        .half16(job_w.half16), .wide(job_w.wide),
        .sys_in_valid(sys_in_valid), .sys_in_data(sys_in_data),
        .sys_in_ready(sys_in_ready),
        .sys_out_valid(sys_out_valid), .sys_out_data(sys_out_data),
        .sys_out_ready(sys_out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy_w), .done(done_w)
    );
endmodule

// File: rtl/wtd_checker.sv
module wtd_checker
    import wtd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_rd,
    input logic [1:0]         reg_sel,
    input logic [15:0]        reg_rdata,
    input logic               irq,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [CARD_AW-1:0] mem_addr,
    input logic               busy
);
    // R2: each moved byte advances the card address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && mem_ack) |=> (!busy || mem_addr == $past(mem_addr) + 20'd1));

    // R6: without a completed handshake the address holds
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !(mem_req && mem_ack)) |=> $stable(mem_addr));

    // R7: the request bit is never seen set while idle
    a_r7_req_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_sel == SEL_CTRL) |-> !reg_rdata[CB_REQ]);

    // R9: the interrupt rises only as a transfer ends
    a_r9_irq_on_tc: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));

    // R10: a control read while idle drops the interrupt
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == SEL_CTRL && !busy) |=> !irq);
endmodule

bind wt_dma_engine wtd_checker u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .busy(busy_w)
);

// File: tb/wt_dma_engine_bench.sv
`timescale 1ns/1ps
module wt_dma_engine_bench;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_sel = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        wide_chan = 0;
    logic [CNT_W-1:0] sys_count = 0;
    logic        sys_in_valid = 0;
    logic [7:0]  sys_in_data = 0;
    logic        sys_in_ready, sys_out_valid;
    logic [7:0]  sys_out_data;
    logic        sys_out_ready = 0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 0;
    logic        mem_ack = 0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]  m_ctrl = 0;
    logic [15:0] m_para = 0;
    logic [7:0]  m_fine = 0;
    logic        m_tc = 0;

    always #2.5 clk = ~clk;

    wt_dma_engine #(.CNT_W(CNT_W)) u_wt_dma_engine (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] f_base(input logic [15:0] p, input logic [7:0] f, input logic w);
        int a;
        a = int'(p) * 16 + int'(f & 8'h0F);
        if (w) a = (a & 'hC0000) + 2 * (a & 'h1FFF0);
        return a[19:0];
    endfunction

    function automatic logic f_flip(input logic [7:0] cv, input logic w, input logic hi);
        if (!cv[7] || cv[1]) return 1'b0;
        if (w && hi) return 1'b1;
        return !cv[6];
    endfunction

    function automatic logic [15:0] f_ctrl_view(input logic w);
        return {8'h00, m_ctrl | {1'b0, m_tc, 6'b0} | {5'b0, w, 2'b0}};
    endfunction

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1; reg_sel = s;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic set_ptr(input logic [15:0] p, input logic [7:0] f);
        wr(2'd2, {8'h00, f});
        wr(2'd1, p);
        m_para = p;
        m_fine = {4'h0, f[3:0]};
    endtask

    task automatic run_xfer(input logic [7:0] cv, input int units, input logic w, input logic rd_end);
        logic [19:0] ea;
        logic [15:0] v;
        logic [15:0] exp_mid;
        int nbytes;
        logic hi;
        wide_chan = w;
        sys_count = CNT_W'(units - 1);
        ea = f_base(m_para, m_fine, w);
        wr(2'd0, {8'h00, cv | 8'h01});
        m_ctrl = cv | 8'h01;
        nbytes = w ? 2 * units : units;
        hi = 0;
        exp_mid = 0;
        for (int i = 0; i < nbytes; ) begin
            logic ack;
            ack = ($urandom % 3) != 0;
            if (!cv[1]) begin
                sys_in_valid = 1; sys_in_data = 8'($urandom);
            end else begin
                sys_out_ready = 1; mem_rdata = 8'($urandom);
            end
            if (rd_end && i == nbytes - 1) begin
                ack = 1; reg_rd = 1; reg_sel = 2'd0;
                exp_mid = f_ctrl_view(w);
            end
            mem_ack = ack;
            #1;
            chk("R6 mem_req", mem_req, 1);
            chk("R2/R3 address", mem_addr, ea);
            chk("R4 mem_we", mem_we, !cv[1]);
            if (!cv[1]) begin
                if (ack) chk("R5 card byte", mem_wdata, sys_in_data ^ {f_flip(cv, w, hi), 7'h00});
            end else begin
                chk("R6 out valid", sys_out_valid, ack);
                if (ack) chk("R4 sys byte", sys_out_data, mem_rdata);
            end
            if (rd_end && i == nbytes - 1)
                chk("R12 read at terminal count", reg_rdata, exp_mid);
            @(negedge clk);
            reg_rd = 0;
            if (ack) begin
                ea = ea + 20'd1;
                i++;
                hi = w ? !hi : 1'b0;
            end
        end
        sys_in_valid = 0; sys_out_ready = 0; mem_ack = 0;
        if (rd_end) begin
            m_ctrl = m_ctrl & 8'hBB;
            m_tc = 0;
        end
        m_para = m_para + 16'(units >> 4);
        m_fine = {4'h0, 4'(units + int'(m_fine))};
        m_ctrl[0] = 0;
        if (cv[5]) m_tc = 1;
        #1 chk("R9 irq after terminal count", irq, m_tc);
        chk("R6 idle mem_req", mem_req, 0);
        rd(2'd1, v); chk("R8 position advance", v, m_para);
        rd(2'd2, v); chk("R8 offset advance", v, {8'h00, m_fine});
        rd(2'd0, v); chk("R10 control read", v, f_ctrl_view(w));
        chk("R7 request bit cleared", v[0], 0);
        m_ctrl = m_ctrl & 8'hBB;
        m_tc = 0;
        #1 chk("R10 irq dropped", irq, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
        rd(2'd0, v); chk("R1 control", v, 16'h0000);
        rd(2'd1, v); chk("R1 position", v, 16'h0000);
        rd(2'd2, v); chk("R1 offset", v, 16'h0000);
        rd(2'd3, v); chk("R1 unused select", v, 16'hFFFF);

        // R11: position write trims the offset register
        wr(2'd2, 16'h00A7);
        rd(2'd2, v); chk("R11 offset before", v, 16'h00A7);
        wr(2'd1, 16'h1234);
        rd(2'd2, v); chk("R11 offset trimmed", v, 16'h0007);
        rd(2'd1, v); chk("R11 position", v, 16'h1234);
        m_para = 16'h1234; m_fine = 8'h07;

        // Narrow, toward card, sign flip, interrupt
        run_xfer(8'hA0, 37, 1'b0, 1'b0);
        // R2 wrap at top of card space
        set_ptr(16'hFFFF, 8'h0F);
        run_xfer(8'h00, 3, 1'b0, 1'b0);
        // R3 wide fold, R5 first byte kept with bit 6
        set_ptr(16'h9ABC, 8'h05);
        run_xfer(8'hE0, 9, 1'b1, 1'b0);
        // R5 wide, both bytes flipped
        run_xfer(8'h80, 20, 1'b1, 1'b0);
        // R4 toward system: no inversion
        run_xfer(8'hA2, 18, 1'b0, 1'b0);
        run_xfer(8'h82, 5, 1'b1, 1'b0);
        // R12 control read in the terminal-count cycle
        run_xfer(8'h20, 4, 1'b0, 1'b1);
        run_xfer(8'hE0, 2, 1'b1, 1'b1);

        for (int k = 0; k < 8; k++) begin
            set_ptr(16'($urandom), 8'($urandom));
            run_xfer(8'($urandom) & 8'hFE, 1 + int'($urandom % 40), 1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule